// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a scratchpad memory shared by a group of parallel lanes. Its word space is split over interleaved banks, with 16 banks and 16 lanes by default. Each lane can put one read or one write on the port in a cycle. Any lane may read a word that another lane wrote.

Two active lanes conflict when they address different words in the same bank. The block finds these conflicts and serves the conflicting accesses in several passes, one pass per cycle. While passes remain it holds `stall` high. The issuing side keeps its request vectors unchanged for as long as `stall` is high. In the first cycle with `stall` low, the last pass runs and the next request may follow.

A lane served in a pass gets an acknowledge, and for a read its data, one cycle after that pass. A request with no conflict therefore completes with single-cycle latency and no stall. No error detection is applied to the stored data.

Top module: `banked_scratch`

## Requirements
- R1: While `rst` is high and for the first cycle after it, `ack` is all zero, `rdata` is all zero, and `stall` is low when no lane is valid.
- R2: The word address of a lane is split into a bank and a row. The bank is the address modulo BANKS, which is the low 4 bits by default, and the row is the upper bits. With the defaults the memory holds 16 banks of 256 words of 32 bits, which is 16 KB.
- R3: When no two active lanes address different words of one bank, `stall` stays low. Every active lane is then served in the issue cycle, and its `ack` bit and read data appear on the next cycle.
- R4: Active lanes that address the same word are served in the same pass, and this does not count as a conflict. This holds for reads of the same word and for a mix of reads and writes to that word.
- R5: A request occupies N passes, where N is the largest number of distinct word addresses among the active lanes of any single bank. `stall` is high during the first N-1 of those cycles.
- R6: Within a bank, each pass serves the address of the lowest-numbered lane that is still pending. Each lane's `ack` bit is high exactly once per request, in the cycle after the pass that served it.
- R7: A lane whose `lane_valid` bit is low gets no `ack`, does not count toward conflicts, and writes nothing to the memory.
- R8: When several active lanes write one address in the same pass, the value from the highest-numbered lane is stored.
- R9: A read served in the same pass as a write to the same word returns the old contents. A later request from any lane returns the written value.
- R10: A request with at most one active lane never raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lane_valid | input | LANES | Per-lane request present |
| lane_we | input | LANES | Per-lane write (1) or read (0) |
| lane_addr | input | LANES*AW | Per-lane word address, lane i at bits [i*AW +: AW] |
| lane_wdata | input | LANES*DW | Per-lane write data, lane i at bits [i*DW +: DW] |
| stall | output | 1 | More passes remain after this cycle; hold the request |
| ack | output | LANES | Lane was served in the previous cycle's pass |
| rdata | output | LANES*DW | Read data of a lane, updated one cycle after its read pass |

## Verification
`stall` is a combinational function of the current request and of which lanes are already served. It is therefore due in the very cycle the request is presented and in each cycle of its replay. `ack` and `rdata` come from one register stage and are due one cycle after the pass that served the lane. The bench drives inputs and samples outputs on the falling edge. It reads `stall` at the falling edge of each pass and collects `ack` and `rdata` at the next falling edge. This lets it count passes and map every lane to the pass that served it.

// File: rtl/banked_scratch.sv
module banked_scratch #(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int ROWS  = 256,
  parameter int DW    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0]              lane_valid,
  input  logic [LANES-1:0]              lane_we,
  input  logic [LANES*$clog2(BANKS*ROWS)-1:0] lane_addr,
  input  logic [LANES*DW-1:0]           lane_wdata,
  output logic                          stall,
  output logic [LANES-1:0]              ack,
  output logic [LANES*DW-1:0]           rdata
);
  localparam int AW = $clog2(BANKS*ROWS);
  localparam int BW = $clog2(BANKS);

  logic [DW-1:0]    mem [BANKS*ROWS];
  logic [AW-1:0]    la  [LANES];
  logic [DW-1:0]    wd  [LANES];
  logic [AW-1:0]    lead [BANKS];
  logic [BANKS-1:0] has;
  logic [LANES-1:0] served, pend, grant;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign la[g] = lane_addr[g*AW +: AW];
    assign wd[g] = lane_wdata[g*DW +: DW];
  end

  assign pend = lane_valid & ~served;

  always_comb begin
    has = '0;
    for (int b = 0; b < BANKS; b++) lead[b] = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pend[l] && !has[la[l][BW-1:0]]) begin
        has[la[l][BW-1:0]]  = 1'b1;
        lead[la[l][BW-1:0]] = la[l];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      grant[l] = pend[l] && (la[l] == lead[la[l][BW-1:0]]);
  end

  assign stall = |(pend & ~grant);

  always_ff @(posedge clk) begin
    if (rst) begin
      served <= '0;
      ack    <= '0;
      rdata  <= '0;
    end else begin
      served <= stall ? (served | grant) : '0;
      ack    <= grant;
      for (int l = 0; l < LANES; l++)
        if (grant[l] && !lane_we[l]) rdata[l*DW +: DW] <= mem[la[l]];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (!rst && grant[l] && lane_we[l]) mem[la[l]] <= wd[l];
  end
endmodule

module scratch_chk #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] lane_valid,
  input logic             stall,
  input logic [LANES-1:0] ack
);
  int run;

  always_ff @(posedge clk) begin
    if (rst)        run <= 0;
    else if (stall) run <= run + 1;
    else            run <= 0;
  end

  assert_ack_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (ack & ~$past(lane_valid)) == '0);

  assert_lone_lane_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_valid) <= 1) |-> !stall);

  assert_stall_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run <= LANES-2));

  assert_pass_progress_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> (ack != '0));
endmodule

bind banked_scratch scratch_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .lane_valid(lane_valid), .stall(stall), .ack(ack)
);

// File: tb/sim_banked_scratch.sv
module sim_banked_scratch;
  localparam int PERIOD = 10;
  localparam int L  = 16;
  localparam int AW = 12;
  localparam int DW = 32;

  // fields: {valid mask[47:32], base[31:16], stride[15:8], expected stall cycles[7:0]}
  localparam logic [47:0] VEC [9] = '{
    {16'hFFFF, 16'd0, 8'd1,  8'd0},
    {16'hFFFF, 16'd0, 8'd2,  8'd1},
    {16'hFFFF, 16'd0, 8'd4,  8'd3},
    {16'hFFFF, 16'd0, 8'd8,  8'd7},
    {16'hFFFF, 16'd0, 8'd16, 8'd15},
    {16'hFFFF, 16'd5, 8'd0,  8'd0},
    {16'hFFFF, 16'd3, 8'd17, 8'd0},
    {16'h0001, 16'd7, 8'd16, 8'd0},
    {16'h00FF, 16'd0, 8'd16, 8'd7}
  };

  logic clk = 0;
  logic rst;
  logic [L-1:0]    lane_valid, lane_we;
  logic [L*AW-1:0] lane_addr;
  logic [L*DW-1:0] lane_wdata;
  logic            stall;
  logic [L-1:0]    ack;
  logic [L*DW-1:0] rdata;

  banked_scratch u0 (.clk(clk), .rst(rst), .lane_valid(lane_valid), .lane_we(lane_we),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata), .stall(stall), .ack(ack), .rdata(rdata));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [L-1:0]  vm, wm;
  logic [AW-1:0] a  [L];
  logic [DW-1:0] wd [L];
  logic [DW-1:0] got [L];
  int ackc [L];
  int pass_at [L];
  int stalls;

  function automatic logic [31:0] fn(input logic [AW-1:0] x);
    return (32'(x) * 32'h9E3779B1) ^ 32'h5A5A5A5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req();
    logic s;
    stalls = 0;
    for (int l = 0; l < L; l++) begin ackc[l] = 0; pass_at[l] = -1; got[l] = '0; end
    @(negedge clk);
    lane_valid = vm; lane_we = wm;
    for (int l = 0; l < L; l++) begin
      lane_addr[l*AW +: AW]  = a[l];
      lane_wdata[l*DW +: DW] = wd[l];
    end
    #1 s = stall;
    for (int p = 0; p < 64; p++) begin
      @(posedge clk); @(negedge clk);
      for (int l = 0; l < L; l++)
        if (ack[l]) begin ackc[l]++; pass_at[l] = p; got[l] = rdata[l*DW +: DW]; end
      if (!s) break;
      stalls++;
      s = stall;
    end
    lane_valid = '0;
  endtask

  task automatic clear_req();
    vm = '0; wm = '0;
    for (int l = 0; l < L; l++) begin a[l] = '0; wd[l] = '0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; lane_valid = '0; lane_we = '0; lane_addr = '0; lane_wdata = '0;
    clear_req();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ack in reset", 32'(ack), 0);
    chk("R1 rdata in reset", 32'(|rdata), 0);
    chk("R1 stall idle", 32'(stall), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 ack after reset", 32'(ack), 0);

    for (int blk = 0; blk < 32; blk++) begin
      vm = '1; wm = '1;
      for (int l = 0; l < L; l++) begin a[l] = AW'(blk*16 + l); wd[l] = fn(a[l]); end
      do_req();
    end
    chk("R3 preload no stall", 32'(stalls), 0);

    for (int v = 0; v < 9; v++) begin
      logic [15:0] msk, base;
      logic [7:0]  st, ex;
      int okd, oka;
      {msk, base, st, ex} = VEC[v];
      clear_req();
      vm = msk;
      for (int l = 0; l < L; l++) a[l] = AW'(base + l*st);
      do_req();
      chk($sformatf("R5 vector %0d stall cycles", v), 32'(stalls), 32'(ex));
      okd = 1; oka = 1;
      for (int l = 0; l < L; l++) begin
        if (ackc[l] != (msk[l] ? 1 : 0)) oka = 0;
        if (msk[l] && got[l] !== fn(a[l])) okd = 0;
      end
      chk($sformatf("R6 R7 vector %0d ack once per active lane", v), 32'(oka), 1);
      chk($sformatf("R3 vector %0d read data", v), 32'(okd), 1);
    end

    clear_req();
    vm = 16'h0003; a[0] = 12'h003; a[1] = 12'h013;
    do_req();
    chk("R2 same bank different row stalls", 32'(stalls), 1);
    clear_req();
    vm = 16'h0003; a[0] = 12'h003; a[1] = 12'h004;
    do_req();
    chk("R2 adjacent words separate banks", 32'(stalls), 0);

    clear_req();
    vm = 16'h000F; a[0] = 12'd32; a[1] = 12'd16; a[2] = 12'd32; a[3] = 12'd0;
    do_req();
    chk("R6 stalls for order case", 32'(stalls), 2);
    chk("R6 lane0 pass", 32'(pass_at[0]), 0);
    chk("R6 lane1 pass", 32'(pass_at[1]), 1);
    chk("R4 lane2 shares lane0 pass", 32'(pass_at[2]), 0);
    chk("R6 lane3 pass", 32'(pass_at[3]), 2);
    chk("R6 lane3 data", got[3], fn(12'd0));

    clear_req();
    vm = 16'h1088; wm = 16'h1088;
    a[3] = 12'd40; a[7] = 12'd40; a[12] = 12'd40;
    wd[3] = 32'h111; wd[7] = 32'h222; wd[12] = 32'h333;
    do_req();
    chk("R8 colliding writes no stall", 32'(stalls), 0);
    clear_req();
    vm = 16'h0001; a[0] = 12'd40;
    do_req();
    chk("R8 highest lane value kept", got[0], 32'h333);

    clear_req();
    vm = 16'h0021; wm = 16'h0001; a[0] = 12'd50; a[5] = 12'd50; wd[0] = 32'hDEAD_BEEF;
    do_req();
    chk("R4 mixed same word no stall", 32'(stalls), 0);
    chk("R9 same pass read old", got[5], fn(12'd50));
    clear_req();
    vm = 16'h0200; a[9] = 12'd50;
    do_req();
    chk("R9 other lane reads new", got[9], 32'hDEAD_BEEF);

    clear_req();
    vm = 16'h0001; wm = 16'h0002; a[0] = 12'd60; a[1] = 12'd76; wd[1] = 32'h0;
    do_req();
    chk("R7 inactive lane no conflict", 32'(stalls), 0);
    chk("R7 inactive lane no ack", 32'(ackc[1]), 0);
    clear_req();
    vm = 16'h0002; a[1] = 12'd76;
    do_req();
    chk("R7 inactive write ignored", got[1], fn(12'd76));

    clear_req();
    vm = 16'h8000; a[15] = 12'd100;
    do_req();
    chk("R10 single lane no stall", 32'(stalls), 0);
    chk("R10 single lane data", got[15], fn(12'd100));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule